// File: doc/BRIEF.md
# Floating-Point Partial Remainder Unit

This unit carries out one pass of round-to-nearest remainder reduction on two normalized, finite floating-point operands: a dividend and a modulus. Each operand is a sign, an unsigned exponent and a 64-bit significand whose top bit is the explicit integer bit. An operand's value is `sig * 2^(exp - 63)`. The modulus is used by magnitude only. The unit takes the gap between the two exponents and chooses one of two paths. When the gap is small enough, it produces the full remainder, with the quotient rounded to the nearest integer. When the gap is larger, it makes a bounded reduction and reports that more passes are needed.

The quotient is built one bit per clock with restoring shift-and-subtract. Only the three least significant quotient bits are kept. On a full reduction they appear on the flag outputs, so that a caller reducing an angle can tell which octant it lies in. The remainder comes back normalized through a leading-zero count and a left shift. A controller drives `start` while `busy` is low and collects the result when the one-cycle `done` pulse arrives. When the controller sees `flag_c2` set, it repeats the operation with the returned value as the new dividend.

Top module: `fprem_unit`

## Requirements
- R1: With D = dividend exponent minus modulus exponent, D < 64 gives a full reduction with `flag_c2` = 0, and D >= 64 gives a partial reduction with `flag_c2` = 1.
- R2: A full reduction returns dividend - modulus*Q, where Q is dividend/modulus rounded to the nearest integer, with an exact half rounded to the even Q. The magnitude of the result never exceeds half the modulus.
- R3: The result sign is the dividend sign. It is inverted when rounding chose the next quotient up from the truncated quotient.
- R4: After a full reduction, `flag_c0` = Q bit 2, `flag_c3` = Q bit 1 and `flag_c1` = Q bit 0, where Q is the magnitude of the rounded quotient.
- R5: When `stk_underflow` is high at start, `flag_c1` is 0 whatever the quotient.
- R6: A partial reduction uses a fixed step count N (parameter, default 32). It returns dividend - modulus*QQ*2^(D-N), with QQ the quotient divided by 2^(D-N) and truncated toward zero. The result exponent is at least 32 below the dividend exponent, and `flag_c0`, `flag_c1` and `flag_c3` are 0.
- R7: A nonzero result has bit 63 of `r_sig` set. A zero result is reported as `r_exp` = 0 and `r_sig` = 0.
- R8: `start` while `busy` is low captures all operand inputs. `busy` then stays high until `done` pulses high for exactly one cycle, and a `start` seen while `busy` is high is ignored.
- R9: When D <= -2, the dividend is returned unchanged and the quotient bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| a_sign | input | 1 | Dividend sign |
| a_exp | input | 15 | Dividend exponent |
| a_sig | input | 64 | Dividend significand, bit 63 set |
| b_exp | input | 15 | Modulus exponent |
| b_sig | input | 64 | Modulus significand, bit 63 set |
| stk_underflow | input | 1 | Forces the bit-0 quotient flag low |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, result valid |
| r_sign | output | 1 | Result sign |
| r_exp | output | 15 | Result exponent |
| r_sig | output | 64 | Result significand, normalized |
| flag_c0 | output | 1 | Quotient bit 2 |
| flag_c1 | output | 1 | Quotient bit 0 (or 0 on underflow) |
| flag_c2 | output | 1 | Reduction incomplete |
| flag_c3 | output | 1 | Quotient bit 1 |

## Verification
Two things can land in the same final cycle: the round-up correction and the quotient flag update. When rounding increments Q, the carry can ripple through the three kept bits at the moment they are published, and the magnitude flips to modulus minus remainder in that cycle too. The bench provokes this with directed halves such as 2.5 and 3.5 times the modulus, an exact multiple of seven, and random operands across gaps from -3 to 81. Each result and each flag is judged against a reference that divides wide integers directly and then rounds.

// File: rtl/fprem_pkg.sv
package fprem_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_DIV   = 2'd1,
    S_ROUND = 2'd2
  } fprem_state_e;
endpackage

// File: rtl/fprem_classify.sv
// Exponent gap analysis: picks the path and the number of divide steps.
module fprem_classify #(
  parameter int EXP_W    = 15,
  parameter int PART_N   = 32,
  parameter int FULL_LIM = 64,
  localparam int CNT_W   = $clog2(FULL_LIM)
) (
  input  logic [EXP_W-1:0] a_exp,
  input  logic [EXP_W-1:0] b_exp,
  output logic             partial,
  output logic             half_gap,
  output logic             tiny,
  output logic [CNT_W-1:0] iters,
  output logic [EXP_W-1:0] base_exp
);
  logic [EXP_W:0] gap;
  logic           neg;

  always_comb begin
    gap      = {1'b0, a_exp} - {1'b0, b_exp};
    neg      = gap[EXP_W];
    partial  = !neg && (gap[EXP_W-1:0] >= EXP_W'(FULL_LIM));
    half_gap = (gap == {(EXP_W+1){1'b1}});
    tiny     = neg && !half_gap;
    if (partial)  iters = CNT_W'(PART_N);
    else if (neg) iters = '0;
    else          iters = gap[CNT_W-1:0];
    base_exp = neg ? a_exp : (a_exp - EXP_W'(iters));
  end
endmodule

// File: rtl/fprem_divstep.sv
// One restoring subtract: emits a quotient bit and the reduced remainder.
module fprem_divstep #(
  parameter int SIG_W = 64
) (
  input  logic [SIG_W:0]   rem,
  input  logic [SIG_W-1:0] divisor,
  output logic             qbit,
  output logic [SIG_W-1:0] rem_next
);
  logic [SIG_W:0] diff;

  always_comb begin
    diff     = rem - {1'b0, divisor};
    qbit     = (rem >= {1'b0, divisor});
    rem_next = qbit ? SIG_W'(diff) : SIG_W'(rem);
  end
endmodule

// File: rtl/fprem_round_norm.sv
// Nearest-even rounding correction followed by renormalization.
module fprem_round_norm #(
  parameter int SIG_W = 64,
  parameter int EXP_W = 15,
  localparam int LZ_W = $clog2(SIG_W) + 1
) (
  input  logic [SIG_W:0]   rem,
  input  logic [SIG_W-1:0] divisor,
  input  logic             half_gap,
  input  logic             no_round,
  input  logic [2:0]       q_lo,
  input  logic [EXP_W-1:0] base_exp,
  input  logic             a_sign,
  output logic             round_up,
  output logic [2:0]       q_out,
  output logic             res_sign,
  output logic [EXP_W-1:0] res_exp,
  output logic [SIG_W-1:0] res_sig
);
  function automatic logic [LZ_W-1:0] lead_zeros(input logic [SIG_W-1:0] v);
    logic [LZ_W-1:0] n;
    logic            hit;
    n   = '0;
    hit = 1'b0;
    for (int i = SIG_W - 1; i >= 0; i--) begin
      if (!hit) begin
        if (v[i]) hit = 1'b1;
        else      n   = n + 1'b1;
      end
    end
    return n;
  endfunction

  logic [SIG_W:0]   unit_div;
  logic [SIG_W+1:0] twice_rem;
  logic [SIG_W-1:0] mag;
  logic [LZ_W-1:0]  lz;

  always_comb begin
    unit_div  = half_gap ? {divisor, 1'b0} : {1'b0, divisor};
    twice_rem = {rem, 1'b0};
    round_up  = !no_round &&
                ((twice_rem > {1'b0, unit_div}) ||
                 ((twice_rem == {1'b0, unit_div}) && q_lo[0]));
    mag       = round_up ? SIG_W'(unit_div - rem) : SIG_W'(rem);
    q_out     = q_lo + {2'b00, round_up};
    res_sign  = a_sign ^ round_up;
    lz        = lead_zeros(mag);
    res_sig   = mag << lz;
    res_exp   = (mag == '0) ? '0 : (base_exp - EXP_W'(lz));
  end
endmodule

// File: rtl/fprem_unit.sv
module fprem_unit
  import fprem_pkg::*;
#(
  parameter int EXP_W    = 15,
  parameter int SIG_W    = 64,
  parameter int PART_N   = 32,
  parameter int FULL_LIM = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             a_sign,
  input  logic [EXP_W-1:0] a_exp,
  input  logic [SIG_W-1:0] a_sig,
  input  logic [EXP_W-1:0] b_exp,
  input  logic [SIG_W-1:0] b_sig,
  input  logic             stk_underflow,
  output logic             busy,
  output logic             done,
  output logic             r_sign,
  output logic [EXP_W-1:0] r_exp,
  output logic [SIG_W-1:0] r_sig,
  output logic             flag_c0,
  output logic             flag_c1,
  output logic             flag_c2,
  output logic             flag_c3
);
  localparam int CNT_W = $clog2(FULL_LIM);

  fprem_state_e     state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SIG_W:0]   rem_q;
  logic [SIG_W-1:0] div_q;
  logic [2:0]       q_q;
  logic [EXP_W-1:0] base_q, a_exp_q;
  logic             sign_q, uf_q, partial_q, tiny_q, half_q;

  logic             cl_partial, cl_half, cl_tiny;
  logic [CNT_W-1:0] cl_iters;
  logic [EXP_W-1:0] cl_base;
  logic             qbit;
  logic [SIG_W-1:0] rem_sub;
  logic             round_up;
  logic [2:0]       rn_q;
  logic             rn_sign;
  logic [EXP_W-1:0] rn_exp;
  logic [SIG_W-1:0] rn_sig;

  // named events for the checker
  logic accept, div_last;
  assign accept   = start && (state_q == S_IDLE);
  assign div_last = (state_q == S_DIV) && (cnt_q == '0);
  assign busy     = (state_q != S_IDLE);

  fprem_classify #(.EXP_W(EXP_W), .PART_N(PART_N), .FULL_LIM(FULL_LIM)) u_cls (
    .a_exp(a_exp), .b_exp(b_exp), .partial(cl_partial), .half_gap(cl_half),
    .tiny(cl_tiny), .iters(cl_iters), .base_exp(cl_base)
  );

  fprem_divstep #(.SIG_W(SIG_W)) u_step (
    .rem(rem_q), .divisor(div_q), .qbit(qbit), .rem_next(rem_sub)
  );

  fprem_round_norm #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_rn (
    .rem(rem_q), .divisor(div_q), .half_gap(half_q), .no_round(partial_q | tiny_q),
    .q_lo(q_q), .base_exp(base_q), .a_sign(sign_q), .round_up(round_up),
    .q_out(rn_q), .res_sign(rn_sign), .res_exp(rn_exp), .res_sig(rn_sig)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      cnt_q     <= '0;
      rem_q     <= '0;
      div_q     <= '0;
      q_q       <= '0;
      base_q    <= '0;
      a_exp_q   <= '0;
      sign_q    <= 1'b0;
      uf_q      <= 1'b0;
      partial_q <= 1'b0;
      tiny_q    <= 1'b0;
      half_q    <= 1'b0;
      done      <= 1'b0;
      r_sign    <= 1'b0;
      r_exp     <= '0;
      r_sig     <= '0;
      flag_c0   <= 1'b0;
      flag_c1   <= 1'b0;
      flag_c2   <= 1'b0;
      flag_c3   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        S_IDLE: if (accept) begin
          rem_q     <= {1'b0, a_sig};
          div_q     <= b_sig;
          cnt_q     <= cl_iters;
          q_q       <= '0;
          base_q    <= cl_base;
          a_exp_q   <= a_exp;
          sign_q    <= a_sign;
          uf_q      <= stk_underflow;
          partial_q <= cl_partial;
          tiny_q    <= cl_tiny;
          half_q    <= cl_half;
          state_q   <= (cl_tiny || cl_half) ? S_ROUND : S_DIV;
        end
        S_DIV: begin
          q_q <= {q_q[1:0], qbit};
          if (div_last) begin
            rem_q   <= {1'b0, rem_sub};
            state_q <= S_ROUND;
          end else begin
            rem_q <= {rem_sub, 1'b0};
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_ROUND: begin
          r_sign  <= rn_sign;
          r_exp   <= rn_exp;
          r_sig   <= rn_sig;
          flag_c2 <= partial_q;
          flag_c0 <= !partial_q && rn_q[2];
          flag_c3 <= !partial_q && rn_q[1];
          flag_c1 <= !partial_q && !uf_q && rn_q[0];
          done    <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fprem_unit_chk.sv
module fprem_unit_chk #(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             uf_q,
  input logic [EXP_W-1:0] a_exp_q,
  input logic [EXP_W-1:0] r_exp,
  input logic [SIG_W-1:0] r_sig,
  input logic             flag_c0,
  input logic             flag_c1,
  input logic             flag_c2,
  input logic             flag_c3
);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(a_exp_q));
  p_partial_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && flag_c2 |-> !flag_c0 && !flag_c1 && !flag_c3);
  p_partial_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && flag_c2 && (r_sig != '0) |->
      ({1'b0, r_exp} + (EXP_W+1)'(32)) <= {1'b0, a_exp_q});
  p_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && uf_q |-> !flag_c1);
  p_norm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && (r_sig != '0) |-> r_sig[SIG_W-1]);
  p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && (r_sig == '0) |-> (r_exp == '0));
endmodule

bind fprem_unit fprem_unit_chk #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .uf_q(uf_q), .a_exp_q(a_exp_q), .r_exp(r_exp), .r_sig(r_sig),
  .flag_c0(flag_c0), .flag_c1(flag_c1), .flag_c2(flag_c2), .flag_c3(flag_c3)
);

// File: tb/fprem_unit_tb.sv
module fprem_unit_tb;
  localparam int PN = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        a_sign = 1'b0;
  logic [14:0] a_exp = '0;
  logic [63:0] a_sig = '0;
  logic [14:0] b_exp = '0;
  logic [63:0] b_sig = '0;
  logic        stk_underflow = 1'b0;
  logic        busy, done, r_sign, flag_c0, flag_c1, flag_c2, flag_c3;
  logic [14:0] r_exp;
  logic [63:0] r_sig;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fprem_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .a_sign(a_sign), .a_exp(a_exp),
    .a_sig(a_sig), .b_exp(b_exp), .b_sig(b_sig), .stk_underflow(stk_underflow),
    .busy(busy), .done(done), .r_sign(r_sign), .r_exp(r_exp), .r_sig(r_sig),
    .flag_c0(flag_c0), .flag_c1(flag_c1), .flag_c2(flag_c2), .flag_c3(flag_c3)
  );

  task automatic check(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference: wide-integer division, then rounding and normalization.
  task automatic model(input logic sa, input logic [14:0] ea, input logic [63:0] siga,
                       input logic [14:0] eb, input logic [63:0] sigb, input logic uf,
                       output logic es, output logic [14:0] ee, output logic [63:0] esig,
                       output logic [3:0] ef, output string tag);
    int d;
    int base;
    logic [127:0] num, den, quo, rem;
    bit part, up;
    d = int'(ea) - int'(eb);
    part = 0;
    if (d >= 64) begin
      num = {64'd0, siga} << PN; den = {64'd0, sigb}; base = int'(ea) - PN; part = 1;
      tag = "R6";
    end else if (d >= 0) begin
      num = {64'd0, siga} << d; den = {64'd0, sigb}; base = int'(eb); tag = "R2";
    end else begin
      num = {64'd0, siga}; den = {64'd0, sigb} << ((d < -2) ? 2 : -d); base = int'(ea);
      tag = (d <= -2) ? "R9" : "R2";
    end
    quo = num / den;
    rem = num % den;
    up = !part && (((rem << 1) > den) || (((rem << 1) == den) && quo[0]));
    if (up) begin quo = quo + 1; rem = den - rem; end
    es = sa ^ up;
    if (rem == 0) ee = '0;
    else begin
      while (!rem[63]) begin rem = rem << 1; base = base - 1; end
      ee = 15'(base);
    end
    esig = rem[63:0];
    // ef = {c3, c2, c1, c0}
    if (part) ef = 4'b0100;
    else ef = {quo[1], 1'b0, quo[0] & ~uf, quo[2]};
  endtask

  task automatic apply(input logic sa, input logic [14:0] ea, input logic [63:0] siga,
                       input logic [14:0] eb, input logic [63:0] sigb, input logic uf,
                       input bit poke_busy);
    logic es; logic [14:0] ee; logic [63:0] esig; logic [3:0] ef; string tag;
    int wait_n;
    model(sa, ea, siga, eb, sigb, uf, es, ee, esig, ef, tag);
    @(negedge clk);
    a_sign = sa; a_exp = ea; a_sig = siga; b_exp = eb; b_sig = sigb; stk_underflow = uf;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke_busy) begin
      check("R8", "busy after start", 128'(busy), 128'(1));
      a_sign = ~sa; a_exp = ea - 15'd3; a_sig = ~siga | 64'h8000_0000_0000_0000;
      stk_underflow = ~uf; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_n = 0;
    while (!done && wait_n < 200) begin @(negedge clk); wait_n++; end
    check("R8", "done arrives", 128'(done), 128'(1));
    check(tag, "significand", 128'(r_sig), 128'(esig));
    check(tag, "exponent", 128'(r_exp), 128'(ee));
    check("R3", "sign", 128'(r_sign), 128'(es));
    check("R1", "c2", 128'(flag_c2), 128'(ef[2]));
    check("R4", "c0/c3", 128'({flag_c3, flag_c0}), 128'({ef[3], ef[0]}));
    check(uf ? "R5" : "R4", "c1", 128'(flag_c1), 128'(ef[1]));
    check("R7", "normalized", 128'(r_sig == 0 ? (r_exp == 0) : r_sig[63]), 128'(1));
    @(negedge clk);
    check("R8", "done one cycle", 128'(done), 128'(0));
  endtask

  function automatic logic [63:0] rsig();
    return {1'b1, 31'($urandom), 32'($urandom)};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R8", "reset busy", 128'(busy), 128'(0));
    check("R8", "reset done", 128'(done), 128'(0));
    rst_n = 1'b1;
    // 2.5 x modulus: tie, even quotient 2
    apply(0, 15'd16001, 64'hA000_0000_0000_0000, 15'd16000, 64'h8000_0000_0000_0000, 0, 0);
    // 3.5 x modulus: tie, rounds up to 4, sign flips (R3)
    apply(0, 15'd16001, 64'hE000_0000_0000_0000, 15'd16000, 64'h8000_0000_0000_0000, 0, 0);
    // exact 7: zero remainder, all three quotient flags set (R4, R7)
    apply(1, 15'd16002, 64'hE000_0000_0000_0000, 15'd16000, 64'h8000_0000_0000_0000, 0, 0);
    // same with underflow (R5)
    apply(1, 15'd16002, 64'hE000_0000_0000_0000, 15'd16000, 64'h8000_0000_0000_0000, 1, 0);
    // gap -1: tie keeps dividend; larger dividend rounds to 1
    apply(0, 15'd15999, 64'hC000_0000_0000_0000, 15'd16000, 64'hC000_0000_0000_0000, 0, 0);
    apply(0, 15'd15999, 64'hF000_0000_0000_0000, 15'd16000, 64'h9000_0000_0000_0000, 0, 0);
    // gap -5: unchanged (R9)
    apply(1, 15'd15995, rsig(), 15'd16000, rsig(), 0, 0);
    // boundaries 63 / 64 (R1) and a large gap (R6)
    apply(0, 15'd16063, rsig(), 15'd16000, rsig(), 0, 0);
    apply(0, 15'd16064, rsig(), 15'd16000, rsig(), 0, 0);
    apply(1, 15'd16200, rsig(), 15'd16000, rsig(), 0, 0);
    // start during busy is ignored (R8)
    apply(0, 15'd16040, rsig(), 15'd16000, rsig(), 0, 1);
    for (int k = 0; k < 250; k++) begin
      int gap;
      logic [14:0] eb;
      gap = int'($urandom_range(84)) - 3;
      eb  = 15'(16000 + int'($urandom_range(200)));
      apply(1'($urandom), 15'(int'(eb) + gap), rsig(), eb, rsig(), 1'($urandom), (k % 17) == 0);
    end
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL R8 watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule